// File: doc/BRIEF.md
# Banked Integer Register File with Privileged Shadow Copies

This block is the integer register file of a CPU core: 32 entries of 64 bits, two combinational read ports and one write port. A fixed, irregular group of register numbers has a second physical copy. While the core runs in privileged mode, accesses to that group reach the shadow copies. In normal mode they reach the ordinary copies. Every other register number maps to one shared entry in both modes.

Switching banks costs no data movement. A single bank-select flip-flop steers every access to the redirected group, and a change takes effect from the next clock cycle. The trap sequencer drives two requests. `enterPriv` is raised on exception entry, but only when the core was not already privileged. `leavePriv` is raised on exception return, together with bit 0 of the saved restart address. A request that would select the bank already in use is flagged as an error and leaves the bank unchanged.

Top module: `shadow_gpr_file`

## Requirements
- R1: After reset `shadowSel` is 1, `swapErr` is 0, and every register reads 0 on both ports in both banks.
- R2: Register numbers 8, 9, 10, 11, 12, 13, 14 and 25 each have two copies. With `shadowSel`=1 reads and writes reach the shadow copy, with `shadowSel`=0 the normal copy, and a write to one copy is not visible through the other.
- R3: Every other register number, including the neighbours 7, 15, 24 and 26, has one copy that is shared by both bank states.
- R4: `enterPriv` alone while `shadowSel`=0 sets `shadowSel` to 1 from the next cycle, and `swapErr` stays 0.
- R5: `enterPriv` alone while `shadowSel`=1 leaves `shadowSel` at 1 and drives `swapErr` to 1 for the next cycle.
- R6: `leavePriv` alone with `restartLsb`=0 while `shadowSel`=1 clears `shadowSel` from the next cycle, with no error.
- R7: `leavePriv` alone with `restartLsb`=1 changes nothing and raises no error.
- R8: `leavePriv` alone with `restartLsb`=0 while `shadowSel`=0 leaves `shadowSel` at 0 and drives `swapErr` to 1 for the next cycle.
- R9: `enterPriv` and `leavePriv` in the same cycle leave `shadowSel` unchanged and drive `swapErr` to 1 for the next cycle.
- R10: Register 31 always reads 0, and writes to it are discarded.
- R11: A write in the same cycle as a bank change lands in the bank that was selected before the change.
- R12: Both read ports are combinational and independent. A value written at a clock edge can be read on either port right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 5 | Read port A register number |
| rdDataA | output | 64 | Read port A data |
| rdAddrB | input | 5 | Read port B register number |
| rdDataB | output | 64 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write register number |
| wrData | input | 64 | Write data |
| enterPriv | input | 1 | Request to select the shadow bank |
| leavePriv | input | 1 | Request to return to the normal bank |
| restartLsb | input | 1 | Bit 0 of the saved restart address, sampled with `leavePriv` |
| shadowSel | output | 1 | 1 while the shadow bank is selected |
| swapErr | output | 1 | One-cycle flag after an illegal or conflicting request |

## Verification
Writes and reads go to redirected numbers (8, 9, 25) and to shared numbers (3, 7, 15), and the bank state is flipped between the write and the read. Only a correct split of the register numbers gives back the written value in one state and zero in the other. Every request is tried against both bank states: enter, leave with each restart bit, and both requests together. This separates a legal swap from an error and from a silent no-op. One write is placed in a swap cycle, which shows which bank captured it. Register 31 and simultaneous reads on both ports cover the remaining datapath corners.

// File: rtl/sgpr_pkg.sv
package sgpr_pkg;
  typedef struct packed {
    logic shadowOn;
    logic wrMain;
    logic wrShadow;
  } sgprStrobe_t;

  // position of a register among the redirected ones
  function automatic int shadowSlot(input logic [31:0] mask, input int addr);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++)
      if (i < addr && mask[i]) n++;
    return n;
  endfunction
endpackage

// File: rtl/sgpr_ctrl.sv
module sgpr_ctrl
  import sgpr_pkg::*;
#(
  parameter int NREGS = 32,
  parameter logic [31:0] SHADOW_MASK = 32'h0200_7F00,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enterPriv,
  input  logic          leavePriv,
  input  logic          restartLsb,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  output sgprStrobe_t   strobe,
  output logic          shadowSel,
  output logic          swapErr
);
  logic shadowQ, errQ;
  logic goShadow, goNormal, badReq, redirected, zeroReg;

  always_comb begin
    goShadow = enterPriv && !leavePriv && !shadowQ;
    goNormal = leavePriv && !enterPriv && !restartLsb && shadowQ;
    badReq   = (enterPriv && leavePriv)
             || (enterPriv && !leavePriv && shadowQ)
             || (leavePriv && !enterPriv && !restartLsb && !shadowQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= 1'b1;
      errQ    <= 1'b0;
    end else begin
      if (goShadow) shadowQ <= 1'b1;
      else if (goNormal) shadowQ <= 1'b0;
      errQ <= badReq;
    end
  end

  always_comb begin
    redirected      = SHADOW_MASK[wrAddr];
    zeroReg         = (wrAddr == AW'(NREGS - 1));
    strobe.shadowOn = shadowQ;
    strobe.wrShadow = wrEn && redirected && shadowQ;
    strobe.wrMain   = wrEn && !zeroReg && !(redirected && shadowQ);
  end

  assign shadowSel = shadowQ;
  assign swapErr   = errQ;
endmodule

// File: rtl/sgpr_data.sv
module sgpr_data
  import sgpr_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN = 64,
  parameter logic [31:0] SHADOW_MASK = 32'h0200_7F00,
  localparam int AW = $clog2(NREGS),
  localparam int NSH = $countones(SHADOW_MASK)
) (
  input  logic            clk,
  input  logic            rstN,
  input  sgprStrobe_t     strobe,
  input  logic [AW-1:0]   wrAddr,
  input  logic [XLEN-1:0] wrData,
  input  logic [AW-1:0]   rdAddrA,
  input  logic [AW-1:0]   rdAddrB,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB
);
  logic [XLEN-1:0] mainQ [NREGS];
  logic [XLEN-1:0] shadowQ [NSH];

  for (genvar r = 0; r < NREGS; r++) begin : g_main
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mainQ[r] <= '0;
      else if (strobe.wrMain && wrAddr == AW'(r)) mainQ[r] <= wrData;
    end
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_shadow
    if (SHADOW_MASK[r]) begin : g_on
      localparam int SLOT = shadowSlot(SHADOW_MASK, r);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shadowQ[SLOT] <= '0;
        else if (strobe.wrShadow && wrAddr == AW'(r)) shadowQ[SLOT] <= wrData;
      end
    end
  end

  function automatic logic [XLEN-1:0] pick(input logic [AW-1:0] a);
    logic [XLEN-1:0] v;
    v = mainQ[a];
    if (strobe.shadowOn && SHADOW_MASK[a])
      v = shadowQ[shadowSlot(SHADOW_MASK, int'(a))];
    if (a == AW'(NREGS - 1)) v = '0;
    return v;
  endfunction

  always_comb begin
    rdDataA = pick(rdAddrA);
    rdDataB = pick(rdAddrB);
  end
endmodule

// File: rtl/shadow_gpr_file.sv
module shadow_gpr_file
  import sgpr_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN = 64,
  parameter logic [31:0] SHADOW_MASK = 32'h0200_7F00,
  localparam int AW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   rdAddrA,
  output logic [XLEN-1:0] rdDataA,
  input  logic [AW-1:0]   rdAddrB,
  output logic [XLEN-1:0] rdDataB,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [XLEN-1:0] wrData,
  input  logic            enterPriv,
  input  logic            leavePriv,
  input  logic            restartLsb,
  output logic            shadowSel,
  output logic            swapErr
);
  sgprStrobe_t strobe;

  sgpr_ctrl #(.NREGS(NREGS), .SHADOW_MASK(SHADOW_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .enterPriv(enterPriv), .leavePriv(leavePriv),
    .restartLsb(restartLsb), .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe),
    .shadowSel(shadowSel), .swapErr(swapErr));

  sgpr_data #(.NREGS(NREGS), .XLEN(XLEN), .SHADOW_MASK(SHADOW_MASK)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB));
endmodule

// File: rtl/sgpr_checker.sv
module sgpr_checker #(
  parameter int XLEN = 64,
  parameter int AW = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic [AW-1:0]   rdAddrA,
  input logic [XLEN-1:0] rdDataA,
  input logic            enterPriv,
  input logic            leavePriv,
  input logic            restartLsb,
  input logic            shadowSel,
  input logic            swapErr
);
  a_r4_enter_ok: assert property (@(posedge clk) disable iff (!rstN)
    (enterPriv && !leavePriv && !shadowSel) |=> (shadowSel && !swapErr));

  a_r5_enter_twice: assert property (@(posedge clk) disable iff (!rstN)
    (enterPriv && !leavePriv && shadowSel) |=> (shadowSel && swapErr));

  a_r6_leave_ok: assert property (@(posedge clk) disable iff (!rstN)
    (leavePriv && !enterPriv && !restartLsb && shadowSel) |=> (!shadowSel && !swapErr));

  a_r7_leave_stay: assert property (@(posedge clk) disable iff (!rstN)
    (leavePriv && !enterPriv && restartLsb) |=> ($stable(shadowSel) && !swapErr));

  a_r8_leave_twice: assert property (@(posedge clk) disable iff (!rstN)
    (leavePriv && !enterPriv && !restartLsb && !shadowSel) |=> (!shadowSel && swapErr));

  a_r9_both_req: assert property (@(posedge clk) disable iff (!rstN)
    (enterPriv && leavePriv) |=> ($stable(shadowSel) && swapErr));

  a_r10_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == AW'(31)) |-> (rdDataA == '0));
endmodule

bind shadow_gpr_file sgpr_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .enterPriv(enterPriv), .leavePriv(leavePriv), .restartLsb(restartLsb),
  .shadowSel(shadowSel), .swapErr(swapErr));

// File: tb/sim_shadow_gpr_file.sv
module sim_shadow_gpr_file;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [63:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, enterPriv = 1'b0, leavePriv = 1'b0, restartLsb = 1'b0;
  logic        shadowSel, swapErr;
  int          nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  shadow_gpr_file u0 (.*);

  typedef struct packed {
    logic       en;
    logic       lv;
    logic       lsb;
    logic       we;
    logic [4:0] wa;
    logic [63:0] wd;
    logic [4:0] ra;
    logic [63:0] ex;
    logic       sh;
    logic       er;
    logic [7:0] rq;
  } vec_t;

  localparam vec_t TBL [0:17] = '{
    '{1'b0,1'b0,1'b0,1'b1,5'd8, 64'hA1,5'd8, 64'hA1,1'b1,1'b0,8'd2},  // R2 shadow write
    '{1'b0,1'b0,1'b0,1'b1,5'd3, 64'hB3,5'd3, 64'hB3,1'b1,1'b0,8'd3},  // R3 shared write
    '{1'b0,1'b1,1'b0,1'b1,5'd9, 64'hC9,5'd9, 64'h0, 1'b0,1'b0,8'd11}, // R11 R6 write in swap
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 64'h0, 5'd8, 64'h0, 1'b0,1'b0,8'd2},  // R2 normal copy empty
    '{1'b0,1'b0,1'b0,1'b1,5'd25,64'hD25,5'd25,64'hD25,1'b0,1'b0,8'd2},// R2 normal r25
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 64'h0, 5'd3, 64'hB3,1'b0,1'b0,8'd3},  // R3 shared seen
    '{1'b0,1'b1,1'b0,1'b0,5'd0, 64'h0, 5'd3, 64'hB3,1'b0,1'b1,8'd8},  // R8 leave twice
    '{1'b1,1'b0,1'b0,1'b0,5'd0, 64'h0, 5'd9, 64'hC9,1'b1,1'b0,8'd4},  // R4 enter, R11 data
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 64'h0, 5'd25,64'h0, 1'b1,1'b0,8'd2},  // R2 shadow r25 empty
    '{1'b1,1'b0,1'b0,1'b0,5'd0, 64'h0, 5'd8, 64'hA1,1'b1,1'b1,8'd5},  // R5 enter twice
    '{1'b0,1'b1,1'b1,1'b0,5'd0, 64'h0, 5'd8, 64'hA1,1'b1,1'b0,8'd7},  // R7 lsb set
    '{1'b1,1'b1,1'b0,1'b0,5'd0, 64'h0, 5'd8, 64'hA1,1'b1,1'b1,8'd9},  // R9 both
    '{1'b0,1'b0,1'b0,1'b1,5'd31,64'hFF,5'd31,64'h0, 1'b1,1'b0,8'd10}, // R10
    '{1'b0,1'b0,1'b0,1'b1,5'd15,64'hE15,5'd15,64'hE15,1'b1,1'b0,8'd3},// R3 r15
    '{1'b0,1'b1,1'b0,1'b0,5'd0, 64'h0, 5'd15,64'hE15,1'b0,1'b0,8'd3}, // R3 R6 r15 shared
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 64'h0, 5'd25,64'hD25,1'b0,1'b0,8'd2}, // R2 normal r25 kept
    '{1'b0,1'b0,1'b0,1'b1,5'd7, 64'h77,5'd7, 64'h77,1'b0,1'b0,8'd3},  // R3 r7
    '{1'b1,1'b0,1'b0,1'b0,5'd0, 64'h0, 5'd7, 64'h77,1'b1,1'b0,8'd3}   // R3 R4 r7 shared
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; enterPriv = 0; leavePriv = 0; restartLsb = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    // R1: reset state in shadow bank
    chk("R1 shadowSel", 64'(shadowSel), 64'd1);
    chk("R1 swapErr", 64'(swapErr), 64'd0);
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(31 - i); #1;
      chk("R1 portA", rdDataA, 64'd0);
      chk("R1 portB", rdDataB, 64'd0);
    end
    // R1: normal bank also clear after reset
    @(negedge clk); leavePriv = 1;
    @(negedge clk); idle();
    for (int i = 8; i < 15; i++) begin
      rdAddrA = 5'(i); #1;
      chk("R1 normal copy", rdDataA, 64'd0);
    end
    rdAddrA = 5'd25; #1; chk("R1 normal r25", rdDataA, 64'd0);
    // back to shadow for the table
    @(negedge clk); enterPriv = 1;
    @(negedge clk); idle();

    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      enterPriv = TBL[k].en; leavePriv = TBL[k].lv; restartLsb = TBL[k].lsb;
      wrEn = TBL[k].we; wrAddr = TBL[k].wa; wrData = TBL[k].wd; rdAddrA = TBL[k].ra;
      @(posedge clk); #2;
      idle();
      #0;
      chk($sformatf("R%0d row%0d data", TBL[k].rq, k), rdDataA, TBL[k].ex);
      chk($sformatf("R%0d row%0d bank", TBL[k].rq, k), 64'(shadowSel), 64'(TBL[k].sh));
      chk($sformatf("R%0d row%0d err", TBL[k].rq, k), 64'(swapErr), 64'(TBL[k].er));
    end

    // R12: write then read on both ports right after the edge
    @(negedge clk); wrEn = 1; wrAddr = 5'd12; wrData = 64'h1212;
    rdAddrA = 5'd12; rdAddrB = 5'd3;
    @(posedge clk); #2; idle();
    chk("R12 portA", rdDataA, 64'h1212);
    chk("R12 portB", rdDataB, 64'hB3);
    // R5: error lasts a single cycle
    @(negedge clk); enterPriv = 1;
    @(negedge clk); idle(); chk("R5 err raised", 64'(swapErr), 64'd1);
    @(negedge clk); chk("R5 err one cycle", 64'(swapErr), 64'd0);
    // R10: writes to r31 leave port B at zero too
    @(negedge clk); wrEn = 1; wrAddr = 5'd31; wrData = '1; rdAddrB = 5'd31;
    @(negedge clk); idle(); chk("R10 portB", rdDataB, 64'd0);
    // R1: reset mid-run
    @(negedge clk); leavePriv = 1;
    @(negedge clk); idle(); rstN = 0; #1; rstN = 1; #1;
    chk("R1 rereset bank", 64'(shadowSel), 64'd1);
    rdAddrA = 5'd3; rdAddrB = 5'd8; #1;
    chk("R1 rereset r3", rdDataA, 64'd0);
    chk("R1 rereset r8", rdDataB, 64'd0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule